// File: doc/BRIEF.md
# Pipelined Memory-Mapped Agent Bridge

This block sits between a pipelined memory-mapped agent port and a strobe-driven register request/response interface. A command on the bus side (a read or a write with a word address, write data and byte enables) is turned into a single-cycle internal request. The request carries a byte address, a write flag, the write data and a per-bit enable mask. The bus uses word addressing, so the bridge scales each word address up to a byte address by the number of byte lanes.

Several commands may be in flight at once, and the internal side may take a different number of cycles to answer each one. Answers come back as acknowledge strobes in request order. Each read acknowledge becomes a read-data-valid pulse and each write acknowledge becomes a write-response-valid pulse, both in the same cycle. An error flag that comes with an acknowledge is reported as an error response code.

Acceptance is held off by the wait output in three cases: a read meets the read stall, a write meets the write stall, or the number of unacknowledged commands has reached its limit.

Top module: `mab_bridge`

## Requirements
- R1: The internal byte address equals the bus word address shifted left by log2(DATA_W/8). With 32-bit data, word address 0x05 gives 0x14 and word address 0x3F gives 0xFC.
- R2: The internal bit enable mask repeats byte enable bit k over bits 8k..8k+7, so byte enables 4'b0101 give 0x00FF00FF. Write data passes through unchanged.
- R3: The request strobe is high in exactly the cycles where a command is presented and the wait output is low. The write flag follows the bus write input.
- R4: While the read stall is high, a presented read raises the wait output and issues no request. A presented write is not affected by the read stall.
- R5: While the write stall is high, a presented write raises the wait output and issues no request. A presented read is not affected by the write stall.
- R6: Once MAX_OUT commands are accepted and not yet acknowledged, any presented command sees the wait output high and no request is made. An acknowledge in that cycle frees a slot from the next cycle on.
- R7: A read acknowledge gives a read-data-valid pulse in the same cycle, with the read data passed through and a response code of 2'b00 when there is no error.
- R8: A write acknowledge gives a write-response-valid pulse in the same cycle, with a response code of 2'b00 when there is no error.
- R9: An acknowledge with its error flag set gives the response code 2'b10. Without an acknowledge the code is 2'b00.
- R10: In reset and when idle, the request strobe, the wait output and both valid pulses are low, and the outstanding count is zero.
- R11: New commands are accepted back to back before any earlier response returns, up to MAX_OUT of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_read | input | 1 | Read command |
| bus_write | input | 1 | Write command |
| bus_addr | input | WORD_AW | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_byteen | input | DATA_W/8 | Byte enables |
| bus_wait | output | 1 | Command not taken this cycle |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_resp | output | 2 | Response code, 2'b00 okay, 2'b10 error |
| bus_wrvalid | output | 1 | Write response valid pulse |
| req | output | 1 | Internal request strobe |
| req_is_wr | output | 1 | Internal request is a write |
| req_addr | output | WORD_AW+log2(DATA_W/8) | Internal byte address |
| req_wdata | output | DATA_W | Internal write data |
| req_biten | output | DATA_W | Internal per-bit write enables |
| stall_rd | input | 1 | Hold off reads |
| stall_wr | input | 1 | Hold off writes |
| rd_ack | input | 1 | Read completion strobe |
| rd_err | input | 1 | Read failed |
| rd_data | input | DATA_W | Read data from register side |
| wr_ack | input | 1 | Write completion strobe |
| wr_err | input | 1 | Write failed |

## Verification
The assertions assume several things about the inputs:
- The bus never raises read and write together.
- A command that meets the wait output keeps its type, address, data and enables until it is taken.
- The register side never acknowledges reads and writes in the same cycle.
- The register side never acknowledges when nothing is outstanding.

The directed stimulus keeps within these assumptions. It holds each stalled or blocked command steady across clock edges. It drives at most one acknowledge per cycle. It balances every acknowledge against a command already taken, counting from reset.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [1:0] {
    RESP_OK  = 2'b00,
    RESP_ERR = 2'b10
  } mab_resp_e;
endpackage

// File: rtl/mab_cmd_map.sv
module mab_cmd_map #(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 8,
  localparam int LANES   = DATA_W / 8,
  localparam int SHIFT   = $clog2(LANES),
  localparam int BYTE_AW = WORD_AW + SHIFT
) (
  input  logic [WORD_AW-1:0] word_addr,
  input  logic [LANES-1:0]   byteen,
  output logic [BYTE_AW-1:0] byte_addr,
  output logic [DATA_W-1:0]  biten
);
  // scale word index to byte offset
  always_comb begin
    byte_addr = BYTE_AW'(word_addr) << SHIFT;
  end

  // fan each lane enable out to its eight data bits
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign biten[8*g +: 8] = {8{byteen[g]}};
  end
endmodule

// File: rtl/mab_pending_ctr.sv
module mab_pending_ctr #(
  parameter int MAX_OUT = 4,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc ^ dec;
    cnt_d  = inc ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full = (cnt_q == CNT_W'(MAX_OUT));
endmodule

// File: rtl/mab_resp_mux.sv
module mab_resp_mux
  import mab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_ack,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ack,
  input  logic              wr_err,
  output logic              rvalid,
  output logic              wrvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        resp
);
  mab_resp_e code;

  always_comb begin
    rvalid  = rd_ack;
    wrvalid = wr_ack;
    rdata   = rd_ack ? rd_data : '0;
    code    = ((rd_ack && rd_err) || (wr_ack && wr_err)) ? RESP_ERR : RESP_OK;
    resp    = code;
  end
endmodule

// File: rtl/mab_bridge.sv
module mab_bridge #(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 8,
  parameter int MAX_OUT = 4,
  localparam int LANES   = DATA_W / 8,
  localparam int BYTE_AW = WORD_AW + $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_read,
  input  logic               bus_write,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [LANES-1:0]   bus_byteen,
  output logic               bus_wait,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic [1:0]         bus_resp,
  output logic               bus_wrvalid,
  output logic               req,
  output logic               req_is_wr,
  output logic [BYTE_AW-1:0] req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  req_biten,
  input  logic               stall_rd,
  input  logic               stall_wr,
  input  logic               rd_ack,
  input  logic               rd_err,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               wr_ack,
  input  logic               wr_err
);
  logic cmd_valid, stall_hit, slots_full;

  always_comb begin
    cmd_valid = bus_read || bus_write;
    stall_hit = (bus_read && stall_rd) || (bus_write && stall_wr);
    bus_wait  = cmd_valid && (stall_hit || slots_full);
    req       = cmd_valid && !bus_wait;
    req_is_wr = bus_write;
    req_wdata = bus_wdata;
  end

  mab_cmd_map #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_map (
    .word_addr (bus_addr),
    .byteen    (bus_byteen),
    .byte_addr (req_addr),
    .biten     (req_biten)
  );

  mab_pending_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (req),
    .dec   (rd_ack || wr_ack),
    .full  (slots_full)
  );

  mab_resp_mux #(.DATA_W(DATA_W)) u_resp (
    .rd_ack  (rd_ack),
    .rd_err  (rd_err),
    .rd_data (rd_data),
    .wr_ack  (wr_ack),
    .wr_err  (wr_err),
    .rvalid  (bus_rvalid),
    .wrvalid (bus_wrvalid),
    .rdata   (bus_rdata),
    .resp    (bus_resp)
  );
endmodule

// File: rtl/mab_bridge_chk.sv
module mab_bridge_chk #(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 8,
  parameter int MAX_OUT = 4,
  localparam int LANES   = DATA_W / 8,
  localparam int BYTE_AW = WORD_AW + $clog2(LANES),
  localparam int SH_W    = $clog2(MAX_OUT + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_read,
  input logic               bus_write,
  input logic [WORD_AW-1:0] bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [LANES-1:0]   bus_byteen,
  input logic               bus_wait,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [1:0]         bus_resp,
  input logic               bus_wrvalid,
  input logic               req,
  input logic [BYTE_AW-1:0] req_addr,
  input logic               stall_rd,
  input logic               stall_wr,
  input logic               rd_ack,
  input logic               rd_err,
  input logic [DATA_W-1:0]  rd_data,
  input logic               wr_ack,
  input logic               wr_err
);
  logic [SH_W-1:0] shadow_q;
  logic            any_ack;

  assign any_ack = rd_ack || wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shadow_q <= '0;
    else if (req && !any_ack) shadow_q <= shadow_q + SH_W'(1);
    else if (!req && any_ack) shadow_q <= shadow_q - SH_W'(1);
  end

  // input assumption (R11 ordering): one acknowledge per cycle
  p_one_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ack && wr_ack));
  // input assumption: acknowledges only when something is outstanding (R6)
  p_ack_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_ack |-> shadow_q != '0);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> shadow_q < SH_W'(MAX_OUT));
  p_full_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q == SH_W'(MAX_OUT) && (bus_read || bus_write)) |-> bus_wait);
  p_rd_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && stall_rd) |-> (bus_wait && !req));
  p_wr_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && stall_wr) |-> (bus_wait && !req));
  p_req_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((bus_read || bus_write) && !bus_wait));
  // input assumption: a waiting command holds still (R3)
  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_wait) |=>
      ($stable(bus_read) && $stable(bus_write) && $stable(bus_addr) &&
       $stable(bus_wdata) && $stable(bus_byteen)));
  p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_addr % BYTE_AW'(LANES)) == '0);
  p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (bus_rvalid && bus_rdata == rd_data));
  p_wrvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (bus_wrvalid && !bus_rvalid));
  p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ack && rd_err) || (wr_ack && wr_err)) |-> bus_resp == 2'b10);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read || bus_write) |-> (!req && !bus_wait));
endmodule

bind mab_bridge mab_bridge_chk #(
  .DATA_W(DATA_W), .WORD_AW(WORD_AW), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_read(bus_read), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_byteen(bus_byteen),
  .bus_wait(bus_wait), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .bus_resp(bus_resp), .bus_wrvalid(bus_wrvalid), .req(req),
  .req_addr(req_addr), .stall_rd(stall_rd), .stall_wr(stall_wr),
  .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
  .wr_ack(wr_ack), .wr_err(wr_err)
);

// File: tb/mab_bridge_tb.sv
module mab_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 32;
  localparam int WORD_AW = 8;
  localparam int MAX_OUT = 4;
  localparam int LANES   = DATA_W / 8;
  localparam int BYTE_AW = WORD_AW + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_read, bus_write;
  logic [WORD_AW-1:0] bus_addr;
  logic [DATA_W-1:0]  bus_wdata;
  logic [LANES-1:0]   bus_byteen;
  logic bus_wait, bus_rvalid, bus_wrvalid;
  logic [DATA_W-1:0]  bus_rdata;
  logic [1:0]         bus_resp;
  logic req, req_is_wr;
  logic [BYTE_AW-1:0] req_addr;
  logic [DATA_W-1:0]  req_wdata, req_biten;
  logic stall_rd, stall_wr, rd_ack, rd_err, wr_ack, wr_err;
  logic [DATA_W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mab_bridge #(.DATA_W(DATA_W), .WORD_AW(WORD_AW), .MAX_OUT(MAX_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_read(bus_read), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_byteen(bus_byteen),
    .bus_wait(bus_wait), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_resp(bus_resp), .bus_wrvalid(bus_wrvalid), .req(req),
    .req_is_wr(req_is_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_biten(req_biten), .stall_rd(stall_rd), .stall_wr(stall_wr),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_ack(wr_ack), .wr_err(wr_err)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_read = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0; bus_byteen = '0;
    stall_rd = 0; stall_wr = 0; rd_ack = 0; rd_err = 0; wr_ack = 0; wr_err = 0;
    rd_data = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!req && !bus_wait, "R10 reset req/wait", {req, bus_wait}, 0);
    check(!bus_rvalid && !bus_wrvalid, "R10 reset valids", {bus_rvalid, bus_wrvalid}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check(!req && !bus_wait, "R10 idle after reset", {req, bus_wait}, 0);
  endtask

  task automatic t_write_basic();
    @(negedge clk);
    bus_write = 1; bus_addr = 8'h05; bus_wdata = 32'hCAFE_1234; bus_byteen = 4'b0101;
    #1;
    check(req && req_is_wr && !bus_wait, "R3 write request", {req, req_is_wr, bus_wait}, 3'b110);
    check(req_addr == 10'h014, "R1 byte address", req_addr, 10'h014);
    check(req_biten == 32'h00FF_00FF, "R2 bit enables", req_biten, 32'h00FF_00FF);
    check(req_wdata == 32'hCAFE_1234, "R2 write data", req_wdata, 32'hCAFE_1234);
    @(negedge clk);
    bus_write = 0; wr_ack = 1;
    #1;
    check(bus_wrvalid && !bus_rvalid, "R8 write response", {bus_wrvalid, bus_rvalid}, 2'b10);
    check(bus_resp == 2'b00, "R8 okay code", bus_resp, 0);
    @(negedge clk); wr_ack = 0;
  endtask

  task automatic t_read_basic();
    @(negedge clk);
    bus_read = 1; bus_addr = 8'h3F;
    #1;
    check(req && !req_is_wr, "R3 read request", {req, req_is_wr}, 2'b10);
    check(req_addr == 10'h0FC, "R1 top word address", req_addr, 10'h0FC);
    @(negedge clk);
    bus_read = 0;
    #1;
    check(!req && !bus_rvalid, "R3 no request when idle", {req, bus_rvalid}, 0);
    @(negedge clk);
    rd_ack = 1; rd_data = 32'h1357_9BDF;
    #1;
    check(bus_rvalid && bus_rdata == 32'h1357_9BDF, "R7 read data", bus_rdata, 32'h1357_9BDF);
    check(bus_resp == 2'b00, "R7 okay code", bus_resp, 0);
    @(negedge clk); rd_ack = 0;
  endtask

  task automatic t_stall_rd();
    @(negedge clk);
    stall_rd = 1; bus_read = 1; bus_addr = 8'h07;
    #1;
    check(bus_wait && !req, "R4 read held", {bus_wait, req}, 2'b10);
    @(negedge clk); #1;
    check(bus_wait && !req, "R4 read still held", {bus_wait, req}, 2'b10);
    @(negedge clk);
    stall_rd = 0;
    #1;
    check(req && !bus_wait, "R4 read released", {req, bus_wait}, 2'b10);
    @(negedge clk);
    bus_read = 0; stall_rd = 1;
    bus_write = 1; bus_addr = 8'h09; bus_byteen = 4'hF;
    rd_ack = 1; rd_data = 32'hA5A5_0001;
    #1;
    check(req && req_is_wr && !bus_wait, "R4 write ignores read stall", {req, bus_wait}, 2'b10);
    check(bus_rvalid && bus_rdata == 32'hA5A5_0001, "R7 read after stall", bus_rdata, 32'hA5A5_0001);
    @(negedge clk);
    bus_write = 0; rd_ack = 0; wr_ack = 1;
    @(negedge clk);
    wr_ack = 0; stall_rd = 0;
  endtask

  task automatic t_stall_wr();
    @(negedge clk);
    stall_wr = 1; bus_write = 1; bus_addr = 8'h11; bus_wdata = 32'h5;
    #1;
    check(bus_wait && !req, "R5 write held", {bus_wait, req}, 2'b10);
    @(negedge clk); #1;
    check(bus_wait && !req, "R5 write still held", {bus_wait, req}, 2'b10);
    @(negedge clk);
    stall_wr = 0;
    #1;
    check(req && req_is_wr, "R5 write released", {req, req_is_wr}, 2'b11);
    @(negedge clk);
    bus_write = 0; stall_wr = 1; bus_read = 1; bus_addr = 8'h12;
    #1;
    check(req && !bus_wait, "R5 read ignores write stall", {req, bus_wait}, 2'b10);
    @(negedge clk);
    bus_read = 0; wr_ack = 1;
    @(negedge clk);
    wr_ack = 0; rd_ack = 1; rd_data = 32'h0;
    @(negedge clk);
    rd_ack = 0; stall_wr = 0;
  endtask

  task automatic t_fill_and_drain();
    for (int i = 0; i < MAX_OUT; i++) begin
      @(negedge clk);
      bus_read = 1; bus_addr = WORD_AW'(i);
      #1;
      check(req && !bus_wait, "R11 back-to-back accept", {req, bus_wait}, 2'b10);
    end
    @(negedge clk);
    bus_addr = 8'h20;
    #1;
    check(bus_wait && !req, "R6 blocked when full", {bus_wait, req}, 2'b10);
    @(negedge clk);
    rd_ack = 1; rd_data = 32'hD000_0000;
    #1;
    check(bus_wait, "R6 still blocked in ack cycle", bus_wait, 1);
    check(bus_rvalid && bus_rdata == 32'hD000_0000, "R7 first drained", bus_rdata, 32'hD000_0000);
    @(negedge clk);
    rd_ack = 0;
    #1;
    check(req && !bus_wait, "R6 slot freed", {req, bus_wait}, 2'b10);
    @(negedge clk);
    bus_read = 0;
    for (int i = 1; i <= MAX_OUT; i++) begin
      rd_ack = 1; rd_err = (i == 2); rd_data = 32'hD000_0000 + DATA_W'(i);
      #1;
      check(bus_rdata == 32'hD000_0000 + DATA_W'(i), "R7 ordered data", bus_rdata,
            32'hD000_0000 + DATA_W'(i));
      check(bus_resp == ((i == 2) ? 2'b10 : 2'b00), "R9 read error code", bus_resp,
            (i == 2) ? 2'b10 : 2'b00);
      @(negedge clk);
    end
    rd_ack = 0; rd_err = 0;
  endtask

  task automatic t_write_err();
    @(negedge clk);
    bus_write = 1; bus_addr = 8'h30;
    @(negedge clk);
    bus_write = 0; wr_ack = 1; wr_err = 1;
    #1;
    check(bus_wrvalid && bus_resp == 2'b10, "R9 write error code", bus_resp, 2'b10);
    @(negedge clk);
    wr_ack = 0; wr_err = 0;
    #1;
    check(bus_resp == 2'b00 && !bus_wrvalid, "R9 code clears", bus_resp, 0);
  endtask

  initial begin
    t_reset();
    t_write_basic();
    t_read_basic();
    t_stall_rd();
    t_stall_wr();
    t_fill_and_drain();
    t_write_err();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule